// File: doc/BRIEF.md
# Atomic Read-Modify-Write Completer

This block carries out atomic memory operations on behalf of a requester. A request names an operation (fetch-and-add, unconditional swap or compare-and-swap), a byte address, an operand size, a tag and up to two operands. The engine fetches the addressed word from a synchronous memory with one cycle of read latency. It computes the replacement value and writes it back when the operation calls for a write. It then returns the value that was in memory before the operation, together with the tag and a status code.

Only one operation is in flight at a time. The request-ready signal drops when a request is taken and rises again only after its completion has been accepted. No other access can reach the memory port between the read and the write. Illegal opcode and size pairs, and misaligned addresses, are answered with an error status and never touch memory.

Memory words are 128 bits wide. An operand sits in the byte lanes picked by the low address bits. The write carries a byte mask, so the neighbouring lanes of the word are left untouched.

Top module: `atomic_rmw_engine`

## Requirements
- R1: Fetch-and-add (opcode 0) stores old value plus `req_opa` at the target, wrapping modulo 2^size; no carry reaches bytes outside the operand.
- R2: Swap (opcode 1) stores `req_opa` at the target whatever the old value.
- R3: Compare-and-swap (opcode 2) stores `req_opa` only when `req_opb` equals the old value; otherwise no write strobe is issued and memory stays unchanged.
- R4: A successful operation completes with status 0 and `cpl_data` holding the pre-operation value, zero-extended to 128 bits.
- R5: A legal operation makes exactly one read cycle (`mem_en`=1, `mem_we`=0), then at most one write cycle, and only then raises `cpl_valid`; the memory port is idle whenever `req_ready` is high.
- R6: Size code 0=32, 1=64, 2=128 bits, 3 reserved; opcode 3 is reserved. Opcodes 0 and 1 accept sizes 0 and 1 only; opcode 2 accepts sizes 0 to 2. Any other pair completes with status 1, `cpl_data` zero and no memory access.
- R7: A legal pair whose address is not a multiple of the operand size completes with status 2, `cpl_data` zero and no memory access. The size check takes priority over the alignment check.
- R8: `req_ready` is low from the accepting edge until the edge at which the completion is accepted. While `cpl_valid` is high and `cpl_ready` low, the completion fields hold steady.
- R9: `cpl_tag` equals the tag of the request being answered, and completions come back in acceptance order.
- R10: After reset `req_ready` is 1, while `cpl_valid` and `mem_en` are 0.
- R11: The memory word index is `req_addr` shifted right by 4. A 32-bit operand sits at byte offset `req_addr[3:2]*4`, a 64-bit operand at `req_addr[3]*8`. `mem_wmask` (bit i enables byte i) covers exactly the operand bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_op | input | 2 | Operation code |
| req_size | input | 2 | Operand size code |
| req_addr | input | AW | Byte address |
| req_tag | input | TW | Requester tag |
| req_opa | input | 128 | Add value or swap value |
| req_opb | input | 128 | Compare value (compare-and-swap only) |
| cpl_valid | output | 1 | Completion offered |
| cpl_ready | input | 1 | Completion taken |
| cpl_tag | output | TW | Tag of the answered request |
| cpl_status | output | 2 | 0 ok, 1 unsupported, 2 misaligned |
| cpl_data | output | 128 | Pre-operation value |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable, qualified by mem_en |
| mem_addr | output | AW-4 | Memory word index |
| mem_wmask | output | 16 | Byte write enables |
| mem_wdata | output | 128 | Write data |
| mem_rdata | input | 128 | Read data, valid one cycle after a read strobe |

## Verification
The properties assume a memory that answers a read strobe with data in the following cycle. They also assume that the requester keeps `req_valid` and its fields steady until the request is taken, and that `cpl_ready` is the only thing that releases a completion. The bench drives a registered-read memory model with byte-masked writes. It holds request fields constant while waiting for `req_ready`, and drops `req_valid` right after the accepting edge. It also stalls `cpl_ready` for several cycles on one request, to exercise the hold rules under back-pressure.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int OPW       = 128;
  localparam int OPB       = OPW / 8;
  localparam int LANE_BITS = $clog2(OPB);
  localparam int SH_BITS   = $clog2(OPW);

  typedef enum logic [1:0] {OP_FADD = 2'd0, OP_SWAP = 2'd1, OP_CAS = 2'd2, OP_RSVD = 2'd3} atom_op_e;
  typedef enum logic [1:0] {SZ_32 = 2'd0, SZ_64 = 2'd1, SZ_128 = 2'd2, SZ_RSVD = 2'd3} atom_sz_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_UNSUP = 2'd1, ST_ALIGN = 2'd2} atom_st_e;

  // low address bits that must be zero for a given size code
  function automatic logic [LANE_BITS-1:0] size_align(input logic [1:0] sz);
    case (sz)
      SZ_32:   size_align = LANE_BITS'(3);
      SZ_64:   size_align = LANE_BITS'(7);
      default: size_align = '1;
    endcase
  endfunction

  // value mask for a given size code, right aligned
  function automatic logic [OPW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_32:   size_mask = OPW'({32{1'b1}});
      SZ_64:   size_mask = OPW'({64{1'b1}});
      default: size_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/atom_req_check.sv
module atom_req_check
  import atom_pkg::*;
(
  input  logic [1:0]           op,
  input  logic [1:0]           size,
  input  logic [LANE_BITS-1:0] addr_lo,
  output logic [1:0]           status
);
  logic combo_ok;

  always_comb begin
    case (op)
      OP_FADD, OP_SWAP: combo_ok = (size == SZ_32) || (size == SZ_64);
      OP_CAS:           combo_ok = (size != SZ_RSVD);
      default:          combo_ok = 1'b0;
    endcase
    if (!combo_ok)
      status = ST_UNSUP;
    else if ((addr_lo & size_align(size)) != '0)
      status = ST_ALIGN;
    else
      status = ST_OK;
  end
endmodule

// File: rtl/atom_lane_alu.sv
module atom_lane_alu
  import atom_pkg::*;
(
  input  logic [1:0]           op,
  input  logic [1:0]           size,
  input  logic [LANE_BITS-1:0] lane_off,
  input  logic [OPW-1:0]       old_word,
  input  logic [OPW-1:0]       opa,
  input  logic [OPW-1:0]       opb,
  output logic [OPW-1:0]       old_val,
  output logic [OPW-1:0]       new_word,
  output logic [OPB-1:0]       byte_mask,
  output logic                 do_write
);
  logic [LANE_BITS-1:0] byte_off;
  logic [SH_BITS-1:0]   shamt;
  logic [OPW-1:0]       val_mask;
  logic [OPW-1:0]       field_mask;
  logic [OPW-1:0]       result;
  logic                 cmp_eq;

  always_comb begin
    val_mask   = size_mask(size);
    byte_off   = lane_off & ~size_align(size);
    shamt      = {byte_off, 3'b000};
    old_val    = (old_word >> shamt) & val_mask;
    cmp_eq     = (old_val == (opb & val_mask));
    case (op)
      OP_FADD: result = (old_val + opa) & val_mask;
      OP_SWAP: result = opa & val_mask;
      OP_CAS:  result = cmp_eq ? (opa & val_mask) : old_val;
      default: result = old_val;
    endcase
    do_write   = (op == OP_CAS) ? cmp_eq : 1'b1;
    field_mask = val_mask << shamt;
    new_word   = (old_word & ~field_mask) | (result << shamt);
  end

  for (genvar g = 0; g < OPB; g++) begin : g_bmask
    assign byte_mask[g] = |field_mask[g*8 +: 8];
  end
endmodule

// File: rtl/atomic_rmw_engine.sv
module atomic_rmw_engine
  import atom_pkg::*;
#(
  parameter int AW = 16,
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [1:0]           req_size,
  input  logic [AW-1:0]        req_addr,
  input  logic [TW-1:0]        req_tag,
  input  logic [OPW-1:0]       req_opa,
  input  logic [OPW-1:0]       req_opb,
  output logic                 cpl_valid,
  input  logic                 cpl_ready,
  output logic [TW-1:0]        cpl_tag,
  output logic [1:0]           cpl_status,
  output logic [OPW-1:0]       cpl_data,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [AW-LANE_BITS-1:0] mem_addr,
  output logic [OPB-1:0]       mem_wmask,
  output logic [OPW-1:0]       mem_wdata,
  input  logic [OPW-1:0]       mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_WR, S_CPL} fsm_e;

  fsm_e                 state;
  logic [1:0]           q_op, q_size;
  logic [LANE_BITS-1:0] q_lane;
  logic [OPW-1:0]       q_opa, q_opb;
  logic [1:0]           chk_status;
  logic [OPW-1:0]       alu_old, alu_new;
  logic [OPB-1:0]       alu_mask;
  logic                 alu_wr;
  logic                 take;

  assign take = req_valid && req_ready;

  atom_req_check u_check (
    .op      (req_op),
    .size    (req_size),
    .addr_lo (req_addr[LANE_BITS-1:0]),
    .status  (chk_status)
  );

  atom_lane_alu u_alu (
    .op        (q_op),
    .size      (q_size),
    .lane_off  (q_lane),
    .old_word  (mem_rdata),
    .opa       (q_opa),
    .opb       (q_opb),
    .old_val   (alu_old),
    .new_word  (alu_new),
    .byte_mask (alu_mask),
    .do_write  (alu_wr)
  );

  // request fields: no reset needed, loaded on acceptance
  always_ff @(posedge clk) begin
    if (take) begin
      q_op   <= req_op;
      q_size <= req_size;
      q_lane <= req_addr[LANE_BITS-1:0];
      q_opa  <= req_opa;
      q_opb  <= req_opb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      req_ready  <= 1'b1;
      cpl_valid  <= 1'b0;
      cpl_tag    <= '0;
      cpl_status <= ST_OK;
      cpl_data   <= '0;
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wmask  <= '0;
      mem_wdata  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (take) begin
            req_ready <= 1'b0;
            cpl_tag   <= req_tag;
            if (chk_status != 2'(ST_OK)) begin
              cpl_status <= chk_status;
              cpl_data   <= '0;
              cpl_valid  <= 1'b1;
              state      <= S_CPL;
            end else begin
              mem_en    <= 1'b1;
              mem_we    <= 1'b0;
              mem_wmask <= '0;
              mem_addr  <= req_addr[AW-1:LANE_BITS];
              state     <= S_RD;
            end
          end
        end
        S_RD: begin
          mem_en <= 1'b0;
          state  <= S_CAP;
        end
        S_CAP: begin
          cpl_data   <= alu_old;
          cpl_status <= ST_OK;
          mem_wdata  <= alu_new;
          mem_wmask  <= alu_mask;
          mem_en     <= alu_wr;
          mem_we     <= alu_wr;
          state      <= S_WR;
        end
        S_WR: begin
          mem_en    <= 1'b0;
          mem_we    <= 1'b0;
          cpl_valid <= 1'b1;
          state     <= S_CPL;
        end
        S_CPL: begin
          if (cpl_ready) begin
            cpl_valid <= 1'b0;
            req_ready <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CPL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> !req_ready); // R8
  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_data) && $stable(cpl_tag) && $stable(cpl_status))); // R8
  AST_WR_THEN_CPL: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |=> (cpl_valid && !mem_en)); // R5
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> (!mem_en && !cpl_valid)); // R5
  AST_IDLE_PORT: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_en); // R5
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (take && chk_status != 2'(ST_OK)) |=> (cpl_valid && !mem_en)); // R6
  AST_WMASK_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> ($countones(mem_wmask) == 4 || $countones(mem_wmask) == 8 || $countones(mem_wmask) == 16)); // R11
endmodule

// File: tb/atomic_rmw_engine_tb.sv
module atomic_rmw_engine_tb;
  localparam int AW = 16;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0, req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tag = '0;
  logic [127:0] req_opa = '0, req_opb = '0;
  logic cpl_valid, cpl_ready = 1'b0;
  logic [TW-1:0] cpl_tag;
  logic [1:0] cpl_status;
  logic [127:0] cpl_data;
  logic mem_en, mem_we;
  logic [AW-5:0] mem_addr;
  logic [15:0] mem_wmask;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;

  always #4 clk = ~clk;

  atomic_rmw_engine #(.AW(AW), .TW(TW)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_size(req_size),
    .req_addr(req_addr), .req_tag(req_tag), .req_opa(req_opa), .req_opb(req_opb),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag),
    .cpl_status(cpl_status), .cpl_data(cpl_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wmask(mem_wmask),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: registered read, byte-masked write
  logic [127:0] mem [16];
  int rd_cnt = 0, wr_cnt = 0;
  logic [15:0] last_mask = '0;
  initial for (int i = 0; i < 16; i++) mem[i] = '0;
  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= mem[mem_addr[3:0]];
      if (mem_we) begin
        for (int b = 0; b < 16; b++)
          if (mem_wmask[b]) mem[mem_addr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        wr_cnt    <= wr_cnt + 1;
        last_mask <= mem_wmask;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  typedef struct packed {
    logic [1:0]   op;
    logic [1:0]   sz;
    logic [7:0]   addr;
    logic [127:0] opa;
    logic [127:0] opb;
    logic [1:0]   st;
    logic [127:0] old;
    logic         wr;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 2'd0, 8'h00, 128'h11111111, 128'h0, 2'd0, 128'h0, 1'b1},                // R2
    '{2'd0, 2'd0, 8'h00, 128'h5, 128'h0, 2'd0, 128'h11111111, 1'b1},                // R1
    '{2'd2, 2'd0, 8'h00, 128'hAAAA0000, 128'h11111116, 2'd0, 128'h11111116, 1'b1},  // R3 match
    '{2'd2, 2'd0, 8'h00, 128'h0000BBBB, 128'h12345678, 2'd0, 128'hAAAA0000, 1'b0},  // R3 miss
    '{2'd0, 2'd0, 8'h00, 128'h0, 128'h0, 2'd0, 128'hAAAA0000, 1'b1},                // R3 unchanged
    '{2'd0, 2'd0, 8'h04, 128'hFFFFFFFF, 128'h0, 2'd0, 128'h0, 1'b1},                // R11
    '{2'd0, 2'd0, 8'h04, 128'h2, 128'h0, 2'd0, 128'hFFFFFFFF, 1'b1},                // R1 wrap
    '{2'd1, 2'd1, 8'h08, 128'h0123456789ABCDEF, 128'h0, 2'd0, 128'h0, 1'b1},        // R2
    '{2'd0, 2'd1, 8'h08, 128'h1, 128'h0, 2'd0, 128'h0123456789ABCDEF, 1'b1},        // R1
    '{2'd0, 2'd0, 8'h04, 128'h0, 128'h0, 2'd0, 128'h1, 1'b1},                       // R1 no carry
    '{2'd1, 2'd0, 8'h02, 128'hDEADBEEF, 128'h0, 2'd2, 128'h0, 1'b0},                // R7
    '{2'd0, 2'd0, 8'h00, 128'h0, 128'h0, 2'd0, 128'hAAAA0000, 1'b1},                // R7 untouched
    '{2'd0, 2'd2, 8'h00, 128'h1, 128'h0, 2'd1, 128'h0, 1'b0},                       // R6
    '{2'd3, 2'd0, 8'h00, 128'h1, 128'h0, 2'd1, 128'h0, 1'b0},                       // R6
    '{2'd2, 2'd2, 8'h10, 128'h44444444333333332222222211111111, 128'h0, 2'd0, 128'h0, 1'b1}, // R3
    '{2'd2, 2'd2, 8'h10, 128'h5, 128'h1, 2'd0, 128'h44444444333333332222222211111111, 1'b0}, // R3
    '{2'd1, 2'd1, 8'h14, 128'h9, 128'h0, 2'd2, 128'h0, 1'b0},                       // R7
    '{2'd0, 2'd0, 8'h14, 128'h0, 128'h0, 2'd0, 128'h22222222, 1'b1},                // R11
    '{2'd1, 2'd1, 8'h20, 128'hFFFFFFFFFFFFFFFF, 128'h0, 2'd0, 128'h0, 1'b1},        // R2
    '{2'd0, 2'd1, 8'h20, 128'h3, 128'h0, 2'd0, 128'hFFFFFFFFFFFFFFFF, 1'b1},        // R1
    '{2'd0, 2'd0, 8'h28, 128'h0, 128'h0, 2'd0, 128'h0, 1'b1},                       // R1 no carry
    '{2'd0, 2'd1, 8'h20, 128'h0, 128'h0, 2'd0, 128'h2, 1'b1},                       // R1 wrap
    '{2'd1, 2'd2, 8'h30, 128'h7, 128'h0, 2'd1, 128'h0, 1'b0},                       // R6
    '{2'd2, 2'd1, 8'h18, 128'h77, 128'h4444444433333333, 2'd0, 128'h4444444433333333, 1'b1}, // R3
    '{2'd0, 2'd1, 8'h18, 128'h0, 128'h0, 2'd0, 128'h77, 1'b1},                      // R3
    '{2'd2, 2'd3, 8'h00, 128'h0, 128'h0, 2'd1, 128'h0, 1'b0},                       // R6
    '{2'd2, 2'd2, 8'h08, 128'h0, 128'h0, 2'd2, 128'h0, 1'b0},                       // R7
    '{2'd0, 2'd0, 8'h08, 128'h0, 128'h0, 2'd0, 128'h89ABCDF0, 1'b1},                // R11
    '{2'd3, 2'd0, 8'h01, 128'h0, 128'h0, 2'd1, 128'h0, 1'b0}                        // R6 before R7
  };

  task automatic run_req(input logic [1:0] op, input logic [1:0] sz, input logic [7:0] addr,
                         input logic [127:0] opa, input logic [127:0] opb, input logic [7:0] tag,
                         input int hold, output logic [1:0] st, output logic [127:0] data,
                         output logic [7:0] tg, output int nrd, output int nwr);
    int rd0, wr0;
    logic [127:0] snap;
    @(negedge clk);
    req_op = op; req_size = sz; req_addr = {8'h00, addr}; req_opa = opa; req_opb = opb;
    req_tag = tag; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R8 ready low after accept", 128'(req_ready), 128'h0);
    while (!cpl_valid) @(negedge clk);
    snap = cpl_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(cpl_valid && cpl_data == snap && cpl_tag == tag && !req_ready,
          "R8 completion held under back-pressure", cpl_data, snap);
    end
    st = cpl_status; data = cpl_data; tg = cpl_tag;
    cpl_ready = 1'b1;
    @(posedge clk);
    #1 cpl_ready = 1'b0;
    nrd = rd_cnt - rd0;
    nwr = wr_cnt - wr0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 128'h0, 128'h1);
    finish_run();
  end

  initial begin
    logic [1:0] st;
    logic [127:0] data;
    logic [7:0] tg;
    int nrd, nwr;
    logic [15:0] emask;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", 128'(req_ready), 128'h1);
    chk(cpl_valid == 1'b0, "R10 no completion after reset", 128'(cpl_valid), 128'h0);
    chk(mem_en == 1'b0, "R10 memory idle after reset", 128'(mem_en), 128'h0);

    for (int v = 0; v < NV; v++) begin
      run_req(VEC[v].op, VEC[v].sz, VEC[v].addr, VEC[v].opa, VEC[v].opb, 8'(v) ^ 8'hA5, 0,
              st, data, tg, nrd, nwr);
      chk(st == VEC[v].st, $sformatf("R4/R6/R7 status vec %0d", v), 128'(st), 128'(VEC[v].st));
      chk(data == VEC[v].old, $sformatf("R4 old value vec %0d", v), data, VEC[v].old);
      chk(tg == (8'(v) ^ 8'hA5), $sformatf("R9 tag vec %0d", v), 128'(tg), 128'(8'(v) ^ 8'hA5));
      chk(nrd == ((VEC[v].st == 2'd0) ? 1 : 0), $sformatf("R5 read count vec %0d", v),
          128'(nrd), 128'((VEC[v].st == 2'd0) ? 1 : 0));
      chk(nwr == (VEC[v].wr ? 1 : 0), $sformatf("R3/R5 write count vec %0d", v),
          128'(nwr), 128'(VEC[v].wr ? 1 : 0));
      if (VEC[v].wr) begin
        case (VEC[v].sz)
          2'd0:    emask = 16'h000F << VEC[v].addr[3:0];
          2'd1:    emask = 16'h00FF << VEC[v].addr[3:0];
          default: emask = 16'hFFFF;
        endcase
        chk(last_mask == emask, $sformatf("R11 byte mask vec %0d", v), 128'(last_mask), 128'(emask));
      end
    end

    // back-pressure on the completion channel
    run_req(2'd1, 2'd0, 8'h30, 128'h5A5A5A5A, 128'h0, 8'hFF, 6, st, data, tg, nrd, nwr);
    chk(st == 2'd0 && data == 128'h0, "R4 swap under stall", data, 128'h0);
    chk(tg == 8'hFF, "R9 tag under stall", 128'(tg), 128'hFF);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready back after completion taken", 128'(req_ready), 128'h1);
    run_req(2'd0, 2'd0, 8'h30, 128'h0, 128'h0, 8'h01, 0, st, data, tg, nrd, nwr);
    chk(data == 128'h5A5A5A5A, "R2 swap value stored", data, 128'h5A5A5A5A);

    // back-to-back ordering of two tags
    run_req(2'd0, 2'd0, 8'h30, 128'h1, 128'h0, 8'h10, 0, st, data, tg, nrd, nwr);
    chk(tg == 8'h10, "R9 first of pair", 128'(tg), 128'h10);
    run_req(2'd0, 2'd0, 8'h30, 128'h1, 128'h0, 8'h20, 0, st, data, tg, nrd, nwr);
    chk(tg == 8'h20 && data == 128'h5A5A5A5B, "R9 second of pair in order", data, 128'h5A5A5A5B);

    finish_run();
  end
endmodule